// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Status Flags

This block moves one byte at a time over a four-wire synchronous serial link, either as the clock-producing master or as a slave clocked from outside. A processor drives it through three byte registers: control, status and data. In master mode, writing the data register starts a transfer. The serial clock runs at one quarter of the system clock, with idle level low and data sampled on the rising edge. Bits go out most significant first.

Four status flags report completion, a write during a transfer, a received byte lost to a full buffer, and a master losing its select line. Each flag has its own set condition and its own clearing sequence. Software can replace the select pin with an internal bit, and an output-disable bit releases the serial data output. One interrupt line reflects the flags when it is enabled.

Top module: `spi_status_port`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read 00h, and `irq_o`, `sck_oe_o`, `mosi_oe_o` and `miso_oe_o` are all low.
- R2: Control bit 0 is the interrupt enable, bit 1 the port enable and bit 2 master mode, and bits 7:3 read 0. In the status register, bits 7..4 are the flags complete, collision, overrun and fault, and they are read-only. Bit 3 reads 0. Bit 2 is output disable, bit 1 selects software select and bit 0 is the software select level. The data register is at address 2.
- R3: In master mode, a data write loads the shift register and produces 8 SCK pulses at clk/4. MOSI carries the byte MSB first and is stable while SCK is high, and MISO is sampled on each rising edge. At the end the complete flag sets and a data read returns the received byte.
- R4: In slave mode with select active, the block samples MOSI on rising `sck_i`, shifts on falling `sck_i` and presents the loaded byte MSB first on MISO. After 8 bits the complete flag sets and the byte can be read from the data register.
- R5: The complete flag clears only when a status read made while it is 1 is followed by a data read or write.
- R6: While the complete flag is 1 and no status read has yet armed its clearing, a data write changes nothing: no transfer starts and the shift register is kept.
- R7: A data write during a transfer sets the collision flag and is discarded, so the transfer carries the original byte. The collision flag clears when a status read made while it is 1 is followed by a data access.
- R8: If a transfer completes while the complete flag is still 1, the overrun flag sets and the receive buffer keeps the earlier byte. Any status read clears the overrun flag.
- R9: If the effective select goes low while the port is enabled as master, the fault flag sets and the port-enable and master bits clear, which drops `sck_oe_o` and `mosi_oe_o`. The fault flag clears only when a control-register access made while it is 1 is followed by a control write.
- R10: When software select is 1 the `ss_ni` pin is ignored and the software level selects: 0 selects, 1 deselects.
- R11: Output disable forces `mosi_oe_o` low in master mode and `miso_oe_o` low in slave mode while the port is enabled.
- R12: `irq_o` is high exactly when the interrupt enable is 1 and at least one of the complete, overrun or fault flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe_o | output | 1 | Master data output enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe_o | output | 1 | Slave data output enable |
| ss_ni | input | 1 | Slave select pin, active low |

## Verification
The critical overlaps are a processor data write landing while the shifter is mid-byte, and a byte completing while the previous completion flag is still unread. The bench provokes the first by issuing a data write half-way through a master transfer. It judges the result by the byte seen on MOSI, which must stay the original one, and by the status reading complete plus collision. It provokes the second by running two slave transfers without servicing the flag. It expects overrun together with complete, then the first byte from the data register.

// File: rtl/spi_sp_pkg.sv
package spi_sp_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  localparam int CtlIrqEn  = 0;
  localparam int CtlEnable = 1;
  localparam int CtlMaster = 2;

  localparam int StsOd  = 2;
  localparam int StsSsm = 1;
  localparam int StsSsi = 0;
endpackage

// File: rtl/spi_sp_sync.sv
module spi_sp_sync #(
  parameter int         W      = 3,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_sp_shifter.sv
module spi_sp_shifter #(
  parameter int W   = 8,
  parameter int DIV = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         master_i,
  input  logic         sel_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         sck_s_i,
  input  logic         mosi_s_i,
  input  logic         miso_i,
  output logic         msb_o,
  output logic         sck_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);
  localparam int BW   = $clog2(W);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic          samp_q, m_busy_q, sck_prev_q;

  logic run_m, slave_act, rise_s, fall_s, m_rise, m_fall, last_bit;

  assign run_m     = en_i & master_i;
  assign slave_act = en_i & ~master_i & sel_i;
  assign rise_s    = sck_s_i & ~sck_prev_q;
  assign fall_s    = ~sck_s_i & sck_prev_q;
  assign m_rise    = m_busy_q & (cnt_q == CW'(HALF - 1));
  assign m_fall    = m_busy_q & (cnt_q == CW'(DIV - 1));
  assign last_bit  = (bit_q == BW'(W - 1));

  assign rx_o   = {sh_q[W-2:0], samp_q};
  assign done_o = (m_fall | (~m_busy_q & slave_act & fall_s)) & last_bit;
  assign msb_o  = sh_q[W-1];
  assign sck_o  = m_busy_q & (cnt_q >= CW'(HALF));
  assign busy_o = m_busy_q | (slave_act & (bit_q != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      bit_q      <= '0;
      samp_q     <= 1'b0;
      m_busy_q   <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      sck_prev_q <= sck_s_i;
      if (load_i) begin
        sh_q <= load_data_i;
        if (run_m) begin
          m_busy_q <= 1'b1;
          cnt_q    <= '0;
          bit_q    <= '0;
        end
      end else if (m_busy_q) begin
        if (!run_m) begin
          m_busy_q <= 1'b0;  // aborted by fault or disable
        end else begin
          cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
          if (m_rise) samp_q <= miso_i;
          if (m_fall) begin
            sh_q  <= rx_o;
            bit_q <= last_bit ? '0 : bit_q + 1'b1;
            if (last_bit) m_busy_q <= 1'b0;
          end
        end
      end else if (slave_act) begin
        if (rise_s) samp_q <= mosi_s_i;
        if (fall_s) begin
          sh_q  <= rx_o;
          bit_q <= last_bit ? '0 : bit_q + 1'b1;
        end
      end else begin
        bit_q <= '0;  // deselected slave restarts at bit 0
      end
    end
  end

  // R3
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_busy_q && run_m && !load_i && cnt_q >= CW'(HALF) && cnt_q != CW'(DIV - 1))
      |=> $stable(sh_q[W-1]));

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_fall && last_bit && !load_i) |=> !m_busy_q);
endmodule

// File: rtl/spi_sp_flags.sv
module spi_sp_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  input  logic data_wr_i,
  input  logic ctrl_acc_i,
  input  logic ctrl_wr_i,
  input  logic busy_i,
  input  logic done_i,
  input  logic fault_i,
  output logic spif_o,
  output logic wcol_o,
  output logic ovr_o,
  output logic modf_o,
  output logic data_wr_ok_o,
  output logic rx_load_o
);
  logic spif_q, spif_arm_q, wcol_q, wcol_arm_q, ovr_q, modf_q, modf_arm_q;
  logic data_acc;

  assign data_acc     = data_rd_i | data_wr_i;
  assign data_wr_ok_o = data_wr_i & ~busy_i & (~spif_q | spif_arm_q);
  assign rx_load_o    = done_i & ~spif_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spif_q     <= 1'b0;
      spif_arm_q <= 1'b0;
      wcol_q     <= 1'b0;
      wcol_arm_q <= 1'b0;
      ovr_q      <= 1'b0;
      modf_q     <= 1'b0;
      modf_arm_q <= 1'b0;
    end else begin
      if (done_i)                       spif_q <= 1'b1;
      else if (data_acc && spif_arm_q)  spif_q <= 1'b0;
      if (data_acc)                     spif_arm_q <= 1'b0;
      else if (stat_rd_i && spif_q)     spif_arm_q <= 1'b1;

      if (data_wr_i && busy_i)          wcol_q <= 1'b1;
      else if (data_acc && wcol_arm_q)  wcol_q <= 1'b0;
      if (data_acc)                     wcol_arm_q <= 1'b0;
      else if (stat_rd_i && wcol_q)     wcol_arm_q <= 1'b1;

      if (done_i && spif_q)             ovr_q <= 1'b1;
      else if (stat_rd_i)               ovr_q <= 1'b0;

      if (fault_i)                      modf_q <= 1'b1;
      else if (ctrl_wr_i && modf_arm_q) modf_q <= 1'b0;
      if (!modf_q || (ctrl_wr_i && modf_arm_q)) modf_arm_q <= 1'b0;
      else if (ctrl_acc_i)              modf_arm_q <= 1'b1;
    end
  end

  assign spif_o = spif_q;
  assign wcol_o = wcol_q;
  assign ovr_o  = ovr_q;
  assign modf_o = modf_q;

  // R3
  spif_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spif_q && !done_i) |=> !spif_q);

  // R5
  spif_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spif_q && !spif_arm_q) |=> spif_q);

  // R7
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && busy_i) |=> wcol_q);

  // R8
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && spif_q) |=> ovr_q);

  // R9
  modf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modf_q && !ctrl_wr_i) |=> modf_q);
endmodule

// File: rtl/spi_status_port.sv
module spi_status_port
  import spi_sp_pkg::*;
#(
  parameter int W   = 8,
  parameter int DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe_o,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe_o,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe_o,
  input  logic       ss_ni
);
  logic irq_en_q, en_q, master_q, od_q, ssm_q, ssi_q;
  logic [W-1:0] rxbuf_q;
  logic sck_s, mosi_s, ss_s, ss_int, sel, fault;
  logic ctrl_wr, ctrl_acc, stat_wr, stat_rd, data_wr, data_rd;
  logic spif, wcol, ovr, modf, data_wr_ok, rx_load, busy, done, msb;
  logic [W-1:0] rx_word;

  assign ctrl_acc = (wr_i | rd_i) & (addr_i == REG_CTRL);
  assign ctrl_wr  = wr_i & (addr_i == REG_CTRL);
  assign stat_wr  = wr_i & (addr_i == REG_STAT);
  assign stat_rd  = rd_i & (addr_i == REG_STAT);
  assign data_wr  = wr_i & (addr_i == REG_DATA);
  assign data_rd  = rd_i & (addr_i == REG_DATA);

  spi_sp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ss_ni, sck_i, mosi_i}),
    .q_o    ({ss_s, sck_s, mosi_s})
  );

  assign ss_int = ssm_q ? ssi_q : ss_s;
  assign sel    = ~ss_int;
  assign fault  = en_q & master_q & ~ss_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      en_q     <= 1'b0;
      master_q <= 1'b0;
      od_q     <= 1'b0;
      ssm_q    <= 1'b0;
      ssi_q    <= 1'b0;
      rxbuf_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        irq_en_q <= wdata_i[CtlIrqEn];
        en_q     <= wdata_i[CtlEnable];
        master_q <= wdata_i[CtlMaster];
      end
      if (fault) begin
        en_q     <= 1'b0;
        master_q <= 1'b0;
      end
      if (stat_wr) begin
        od_q  <= wdata_i[StsOd];
        ssm_q <= wdata_i[StsSsm];
        ssi_q <= wdata_i[StsSsi];
      end
      if (rx_load) rxbuf_q <= rx_word;
    end
  end

  spi_sp_shifter #(.W(W), .DIV(DIV)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .master_i    (master_q),
    .sel_i       (sel),
    .load_i      (data_wr_ok),
    .load_data_i (wdata_i[W-1:0]),
    .sck_s_i     (sck_s),
    .mosi_s_i    (mosi_s),
    .miso_i      (miso_i),
    .msb_o       (msb),
    .sck_o       (sck_o),
    .busy_o      (busy),
    .done_o      (done),
    .rx_o        (rx_word)
  );

  spi_sp_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stat_rd_i    (stat_rd),
    .data_rd_i    (data_rd),
    .data_wr_i    (data_wr),
    .ctrl_acc_i   (ctrl_acc),
    .ctrl_wr_i    (ctrl_wr),
    .busy_i       (busy),
    .done_i       (done),
    .fault_i      (fault),
    .spif_o       (spif),
    .wcol_o       (wcol),
    .ovr_o        (ovr),
    .modf_o       (modf),
    .data_wr_ok_o (data_wr_ok),
    .rx_load_o    (rx_load)
  );

  always_comb begin
    unique case (addr_i)
      REG_CTRL: rdata_o = {5'b0, master_q, en_q, irq_en_q};
      REG_STAT: rdata_o = {spif, wcol, ovr, modf, 1'b0, od_q, ssm_q, ssi_q};
      REG_DATA: rdata_o = 8'(rxbuf_q);
      default:  rdata_o = 8'h00;
    endcase
  end

  assign irq_o     = irq_en_q & (spif | ovr | modf);
  assign sck_oe_o  = en_q & master_q;
  assign mosi_o    = msb;
  assign mosi_oe_o = en_q & master_q & ~od_q;
  assign miso_o    = msb;
  assign miso_oe_o = en_q & ~master_q & sel & ~od_q;

  // R9
  fault_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> (!en_q && !master_q && modf));

  // R8
  rx_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && spif) |=> $stable(rxbuf_q));
endmodule

// File: tb/spi_status_port_bench.sv
module spi_status_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_status_port u_spi_status_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe),
    .ss_ni(ss_n)
  );

  function automatic logic [7:0] sts(input bit spif, wcol, ovr, modf,
                                     input bit od, ssm, ssi);
    return {spif, wcol, ovr, modf, 1'b0, od, ssm, ssi};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    cpu_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic mxfer(input logic [7:0] tx, input logic [7:0] sl, input bit coll,
                       output logic [7:0] got);
    miso_i = sl[7];
    got = 8'h00;
    cpu_wr(2'd2, tx);
    for (int i = 0; i < 8; i++) begin
      @(posedge sck_o);
      got = {got[6:0], mosi_o};
      if (coll && i == 3) cpu_wr(2'd2, ~tx);
      @(negedge sck_o);
      if (i < 7) miso_i = sl[6-i];
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic sxfer(input logic [7:0] tx, input bit drive_ss, output logic [7:0] got);
    got = 8'h00;
    if (drive_ss) ss_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      mosi_i = tx[7-i];
      repeat (6) @(negedge clk);
      sck_i = 1'b1;
      got = {got[6:0], miso_o};
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    if (drive_ss) ss_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] got, tx, sl;
    int highs;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 ctrl", 2'd0, 8'h00);
    rd_chk("R1 status", 2'd1, 8'h00);
    chk("R1 outputs", {4'b0, irq, sck_oe, mosi_oe, miso_oe}, 8'h00);

    // R2 register map
    cpu_wr(2'd0, 8'hFF);
    rd_chk("R2 ctrl bits", 2'd0, 8'h07);
    cpu_wr(2'd1, 8'hFF);
    rd_chk("R2 status writable bits", 2'd1, 8'h07);
    cpu_wr(2'd1, 8'h03);

    // R3 R12 directed master transfer
    mxfer(8'hA5, 8'h3C, 1'b0, got);
    chk("R3 mosi byte", got, 8'hA5);
    chk("R12 irq on complete", {7'b0, irq}, 8'h01);
    rd_chk("R3 status complete", 2'd1, sts(1,0,0,0,0,1,1));
    rd_chk("R3 rx byte", 2'd2, 8'h3C);
    rd_chk("R5 status cleared", 2'd1, sts(0,0,0,0,0,1,1));
    chk("R12 irq low", {7'b0, irq}, 8'h00);

    // R3 R5 random master transfers
    for (int n = 0; n < 16; n++) begin
      tx = 8'($urandom);
      sl = 8'($urandom);
      mxfer(tx, sl, 1'b0, got);
      chk("R3 rnd mosi", got, tx);
      rd_chk("R3 rnd status", 2'd1, sts(1,0,0,0,0,1,1));
      rd_chk("R3 rnd rx", 2'd2, sl);
      rd_chk("R5 rnd clear", 2'd1, sts(0,0,0,0,0,1,1));
    end

    // R12 interrupt disabled
    cpu_wr(2'd0, 8'h06);
    mxfer(8'h0F, 8'hF0, 1'b0, got);
    chk("R12 irq masked", {7'b0, irq}, 8'h00);
    rd_chk("R12 status", 2'd1, sts(1,0,0,0,0,1,1));
    rd_chk("R12 rx", 2'd2, 8'hF0);
    cpu_wr(2'd0, 8'h07);

    // R6 blocked write while complete set
    mxfer(8'h11, 8'h22, 1'b0, got);
    cpu_wr(2'd2, 8'h99);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sck_o) highs++;
    end
    chk("R6 no sck after blocked write", 8'(highs), 8'h00);
    chk("R6 shift reg kept", {7'b0, mosi_o}, 8'h00);
    rd_chk("R6 status still complete", 2'd1, sts(1,0,0,0,0,1,1));
    mxfer(8'h44, 8'h55, 1'b0, got);
    chk("R6 armed write starts", got, 8'h44);
    rd_chk("R5 status after armed write", 2'd1, sts(1,0,0,0,0,1,1));
    rd_chk("R5 rx", 2'd2, 8'h55);

    // R7 collision mid transfer
    mxfer(8'h5A, 8'h81, 1'b1, got);
    chk("R7 original byte sent", got, 8'h5A);
    rd_chk("R7 status collision", 2'd1, sts(1,1,0,0,0,1,1));
    rd_chk("R7 rx", 2'd2, 8'h81);
    rd_chk("R7 collision cleared", 2'd1, sts(0,0,0,0,0,1,1));

    // R11 output disable in master mode
    cpu_wr(2'd1, 8'h07);
    chk("R11 master od", {7'b0, mosi_oe}, 8'h00);
    cpu_wr(2'd1, 8'h03);
    chk("R11 master od off", {7'b0, mosi_oe}, 8'h01);

    // R9 mode fault
    cpu_wr(2'd1, 8'h00);
    ss_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 outputs dropped", {6'b0, sck_oe, mosi_oe}, 8'h00);
    chk("R12 irq on fault", {7'b0, irq}, 8'h01);
    rd_chk("R9 ctrl cleared", 2'd0, 8'h01);
    rd_chk("R9 status fault", 2'd1, sts(0,0,0,1,0,0,0));
    cpu_wr(2'd0, 8'h00);
    rd_chk("R9 fault cleared", 2'd1, 8'h00);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    cpu_wr(2'd0, 8'h07);
    ss_n = 1'b0;
    repeat (5) @(negedge clk);
    cpu_wr(2'd0, 8'h01);
    rd_chk("R9 single write keeps fault", 2'd1, sts(0,0,0,1,0,0,0));
    cpu_wr(2'd0, 8'h00);
    rd_chk("R9 second write clears", 2'd1, 8'h00);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 slave transfer with hardware select
    cpu_wr(2'd0, 8'h03);
    cpu_wr(2'd2, 8'hC3);
    sxfer(8'h96, 1'b1, got);
    chk("R4 miso byte", got, 8'hC3);
    chk("R4 miso released", {7'b0, miso_oe}, 8'h00);
    rd_chk("R4 status", 2'd1, sts(1,0,0,0,0,0,0));
    rd_chk("R4 rx", 2'd2, 8'h96);
    rd_chk("R4 cleared", 2'd1, 8'h00);

    // R8 overrun
    cpu_wr(2'd2, 8'h00);
    sxfer(8'h11, 1'b1, got);
    sxfer(8'h22, 1'b1, got);
    rd_chk("R8 status overrun", 2'd1, sts(1,0,1,0,0,0,0));
    rd_chk("R8 overrun cleared by read", 2'd1, sts(1,0,0,0,0,0,0));
    rd_chk("R8 first byte kept", 2'd2, 8'h11);
    rd_chk("R8 all clear", 2'd1, 8'h00);

    // R10 software select
    cpu_wr(2'd1, 8'h02);
    chk("R10 soft select active", {7'b0, miso_oe}, 8'h01);
    cpu_wr(2'd2, 8'h6E);
    sxfer(8'h3D, 1'b0, got);
    chk("R10 miso byte", got, 8'h6E);
    rd_chk("R10 status", 2'd1, sts(1,0,0,0,0,1,0));
    rd_chk("R10 rx", 2'd2, 8'h3D);
    cpu_wr(2'd1, 8'h03);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 pin ignored", {7'b0, miso_oe}, 8'h00);
    ss_n = 1'b1;

    // R11 output disable in slave mode
    cpu_wr(2'd1, 8'h04);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 slave od", {7'b0, miso_oe}, 8'h00);
    cpu_wr(2'd1, 8'h00);
    chk("R11 slave od off", {7'b0, miso_oe}, 8'h01);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule